// File: doc/BRIEF.md
# Non-Maskable Event Power-Stage Shutdown Controller

This block guards a three-phase motor power stage against a critical external event. An asynchronous event line is first brought into the clock domain through a two-stage synchroniser. A stability filter then accepts a new level only after the line has held that level for a programmable number of cycles. When the filtered line rises, the block takes the six phase drivers off in the same clock cycle, without software. One cycle later it sets a sticky status flag and raises a non-maskable request towards the processor.

The two flags are cleared by different agents. The processor-side pending bit drops when the processor acknowledges the request. The status flag drops only on a software write. Once shut down, the phase drivers stay released until software has cleared the status flag and then writes a separate re-enable command. Two control bits select the response independently, so the line can be used only to force the shutdown, only to interrupt, or for both. The input is edge-sensitive. A line that stays active produces a single event, however often software clears the flag.

Top module: `nmi_shutdown_ctrl`

## Requirements
- R1: After reset, all six `phase_oe` bits are 1 and `phase_out` equals `pwm_in`. `cpu_nmi_req` is 0, the status register (address 1) reads 0, the control register (address 0) reads 0x03 and the filter register (address 2) reads 4.
- R2: The event line passes two synchroniser flops. The filtered level changes only after the synchronised line has differed from it for FILT consecutive cycles, where FILT is the filter register value and 0 acts as 1. A pulse shorter than FILT cycles produces no event.
- R3: The line changes at a falling clock edge. With shutdown enable (control bit 0) set, `phase_oe` and `phase_out` both read 0 after 2+FILT rising edges, and not before.
- R4: Every accepted rising edge sets the status flag (status bit 0) one cycle after the event, whatever the enables are. Only a status write with bit 0 = 1 clears it. If an event and a clearing write fall in the same cycle, the flag ends up set.
- R5: With request enable (control bit 1) set, an event sets the pending bit one cycle later, and `cpu_nmi_req` shows it. `cpu_nmi_ack` clears it. If an event and an acknowledge fall in the same cycle, the request stays set.
- R6: A new event needs the filtered line to go inactive and then rise again. Clearing the flag while the line is still active produces no new event.
- R7: Once shut down, the drivers stay off until a status write with bit 1 = 1 arrives while the status flag already reads 0. That write restores `phase_oe` = all ones and `phase_out` = `pwm_in`. While the flag is set, the write is ignored. Status bit 1 reads the shutdown state and bit 2 reads the filtered line level.
- R8: With shutdown enable 0, an event leaves `phase_oe` at all ones but still sets the flag and the request. With request enable 0, an event shuts the drivers down but does not raise `cpu_nmi_req`.
- R9: The control and filter registers read back what was written. Address 3 and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_in | input | 1 | Asynchronous event line, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pwm_in | input | 6 | Phase drive levels from the PWM generator |
| phase_out | output | 6 | Phase levels to the pads, 0 while shut down |
| phase_oe | output | 6 | Pad output enables, 0 = high impedance |
| cpu_nmi_req | output | 1 | Non-maskable request to the processor |
| cpu_nmi_ack | input | 1 | Processor acknowledge of the request |

## Verification
Two pairs of actions can land on the same clock edge: an accepted event with a software write that clears the status flag, and an accepted event with a processor acknowledge. The bench provokes each pair by counting the known latency of 2+FILT edges from the line change. It places the clearing write or the acknowledge on the edge where the event pulse is sampled. It then judges the result by reading the flag, or `cpu_nmi_req`, the next cycle: both must still be set, because a new event takes priority over a clear.

// File: rtl/nmi_sd_pkg.sv
package nmi_sd_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_FILT = 2'd2;

  // control register fields
  localparam int B_SHUT = 0;
  localparam int B_REQ  = 1;
  // status register fields
  localparam int B_FLAG = 0;
  localparam int B_OFF  = 1;  // read: shutdown state, write 1: re-enable
  localparam int B_LVL  = 2;

  // true when one more differing cycle completes the stability window
  function automatic logic window_done(input int unsigned cnt, input int unsigned len);
    int unsigned eff;
    eff = (len == 0) ? 1 : len;
    return (cnt + 1) >= eff;
  endfunction
endpackage

// File: rtl/nmi_sd_sync.sv
module nmi_sd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_sd_filter.sv
module nmi_sd_filter
  import nmi_sd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [CNT_W-1:0] len,
  output logic             lvl,
  output logic             rise
);
  logic [CNT_W-1:0] cnt_q;
  logic             lvl_q;
  logic             rise_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      if (din == lvl_q) begin
        cnt_q <= '0;
      end else if (window_done(32'(cnt_q), 32'(len))) begin
        lvl_q  <= din;
        cnt_q  <= '0;
        rise_q <= din;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lvl  = lvl_q;
  assign rise = rise_q;
endmodule

// File: rtl/nmi_sd_regs.sv
module nmi_sd_regs
  import nmi_sd_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 8,
  parameter int FILT_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              evt,
  input  logic              lvl,
  output logic [DATA_W-1:0] rdata,
  output logic              shut_en,
  output logic              req_en,
  output logic [CNT_W-1:0]  filt_len,
  output logic              flag,
  output logic              off,
  output logic              clr_wr,
  output logic              reen_wr
);
  logic stat_wr;

  assign stat_wr = wr && (addr == A_STAT);
  assign clr_wr  = stat_wr && wdata[B_FLAG];
  assign reen_wr = stat_wr && wdata[B_OFF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shut_en  <= 1'b1;
      req_en   <= 1'b1;
      filt_len <= CNT_W'(FILT_RST);
    end else if (wr) begin
      if (addr == A_CTRL) begin
        shut_en <= wdata[B_SHUT];
        req_en  <= wdata[B_REQ];
      end
      if (addr == A_FILT) filt_len <= CNT_W'(wdata);
    end
  end

  // event wins over a clearing write in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (evt)    flag <= 1'b1;
    else if (clr_wr) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 off <= 1'b0;
    else if (evt && shut_en)    off <= 1'b1;
    else if (reen_wr && !flag)  off <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[B_SHUT] = shut_en;
        rdata[B_REQ]  = req_en;
      end
      A_STAT: begin
        rdata[B_FLAG] = flag;
        rdata[B_OFF]  = off;
        rdata[B_LVL]  = lvl;
      end
      A_FILT:  rdata = DATA_W'(filt_len);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/nmi_sd_cpu.sv
module nmi_sd_cpu (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic req_en,
  input  logic ack,
  output logic req
);
  logic pend_q;

  // a new event outranks the acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pend_q <= 1'b0;
    else if (evt && req_en)   pend_q <= 1'b1;
    else if (ack)             pend_q <= 1'b0;
  end

  assign req = pend_q;
endmodule

// File: rtl/nmi_shutdown_ctrl.sv
module nmi_shutdown_ctrl
  import nmi_sd_pkg::*;
#(
  parameter int N_PHASE  = 6,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 8,
  parameter int SYNC_N   = 2,
  parameter int FILT_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_PHASE-1:0] pwm_in,
  output logic [N_PHASE-1:0] phase_out,
  output logic [N_PHASE-1:0] phase_oe,
  output logic              cpu_nmi_req,
  input  logic              cpu_nmi_ack
);
  logic             line_sync;
  logic             lvl;
  logic             evt;
  logic             shut_en;
  logic             req_en;
  logic [CNT_W-1:0] filt_len;
  logic             flag;
  logic             off;
  logic             clr_wr;
  logic             reen_wr;
  logic             kill;

  nmi_sd_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(nmi_in), .dout(line_sync)
  );

  nmi_sd_filter #(.CNT_W(CNT_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .din(line_sync), .len(filt_len),
    .lvl(lvl), .rise(evt)
  );

  nmi_sd_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .FILT_RST(FILT_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .evt(evt), .lvl(lvl), .rdata(reg_rdata), .shut_en(shut_en), .req_en(req_en),
    .filt_len(filt_len), .flag(flag), .off(off), .clr_wr(clr_wr), .reen_wr(reen_wr)
  );

  nmi_sd_cpu u_cpu (
    .clk(clk), .rst_n(rst_n), .evt(evt), .req_en(req_en),
    .ack(cpu_nmi_ack), .req(cpu_nmi_req)
  );

  // drivers released in the very cycle the event is seen
  assign kill = off | (evt & shut_en);

  for (genvar g = 0; g < N_PHASE; g++) begin : g_phase
    assign phase_oe[g]  = ~kill;
    assign phase_out[g] = pwm_in[g] & ~kill;
  end
endmodule

// File: rtl/nmi_sd_chk.sv
module nmi_sd_chk #(
  parameter int N_PHASE = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               evt,
  input logic               lvl,
  input logic               shut_en,
  input logic               req_en,
  input logic               flag,
  input logic               off,
  input logic               clr_wr,
  input logic               reen_wr,
  input logic               cpu_nmi_ack,
  input logic               cpu_nmi_req,
  input logic [N_PHASE-1:0] phase_oe
);
  a_r3_oe_off_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    evt && shut_en |-> phase_oe == '0);

  a_r4_flag_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr_wr |=> flag);

  a_r5_req_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    evt && req_en |=> cpu_nmi_req);

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_nmi_ack && !(evt && req_en) |=> !cpu_nmi_req);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);

  a_r6_event_at_high: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> lvl);

  a_r7_off_held: assert property (@(posedge clk) disable iff (!rst_n)
    off && flag |=> off);

  a_r8_no_kill_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !shut_en && !off |-> phase_oe == '1);
endmodule

bind nmi_shutdown_ctrl nmi_sd_chk #(.N_PHASE(N_PHASE)) u_chk (.*);

// File: tb/sim_nmi_shutdown_ctrl.sv
module sim_nmi_shutdown_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       nmi_in;
  logic       reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [5:0] pwm_in;
  logic [5:0] phase_out;
  logic [5:0] phase_oe;
  logic       cpu_nmi_req;
  logic       cpu_nmi_ack;

  int checks = 0;
  int errors = 0;
  int filt   = 4;

  always #5 clk = ~clk;

  nmi_shutdown_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwm_in(pwm_in), .phase_out(phase_out), .phase_oe(phase_oe),
    .cpu_nmi_req(cpu_nmi_req), .cpu_nmi_ack(cpu_nmi_ack)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic ack_pulse();
    cpu_nmi_ack = 1'b1;
    tick(1);
    cpu_nmi_ack = 1'b0;
  endtask

  task automatic cleanup();
    nmi_in = 1'b0;
    tick(filt + 4);
    wr(2'd1, 8'h01);
    wr(2'd1, 8'h02);
    ack_pulse();
    tick(1);
  endtask

  task automatic t_reset();
    int v;
    chk("R1", "oe after reset", int'(phase_oe), 63);
    chk("R1", "phase_out follows pwm", int'(phase_out), int'(pwm_in));
    chk("R1", "req after reset", int'(cpu_nmi_req), 0);
    rd(2'd1, v); chk("R1", "status after reset", v, 0);
    rd(2'd0, v); chk("R1", "ctrl after reset", v, 3);
    rd(2'd2, v); chk("R1", "filter after reset", v, 4);
  endtask

  task automatic t_glitch();
    int v;
    nmi_in = 1'b1; tick(filt - 1); nmi_in = 1'b0;
    tick(filt + 4);
    chk("R2", "short pulse oe", int'(phase_oe), 63);
    rd(2'd1, v); chk("R2", "short pulse status", v, 0);
    chk("R2", "short pulse req", int'(cpu_nmi_req), 0);
    wr(2'd2, 8'd2); filt = 2;
    nmi_in = 1'b1; tick(1); nmi_in = 1'b0;
    tick(6);
    rd(2'd1, v); chk("R2", "1-cycle pulse at filter 2", v, 0);
    nmi_in = 1'b1; tick(2); nmi_in = 1'b0;
    tick(6);
    rd(2'd1, v); chk("R2", "2-cycle pulse at filter 2 flag", v & 1, 1);
    cleanup();
    wr(2'd2, 8'd4); filt = 4;
    chk("R2", "oe after cleanup", int'(phase_oe), 63);
  endtask

  task automatic t_main();
    int v;
    nmi_in = 1'b1;
    tick(1 + filt);
    chk("R3", "oe one edge before shutdown", int'(phase_oe), 63);
    tick(1);
    chk("R3", "oe at shutdown edge", int'(phase_oe), 0);
    chk("R3", "phase_out at shutdown", int'(phase_out), 0);
    rd(2'd1, v); chk("R4", "flag not yet set", v & 1, 0);
    chk("R5", "req not yet set", int'(cpu_nmi_req), 0);
    tick(1);
    rd(2'd1, v); chk("R4", "flag set", v & 1, 1);
    chk("R7", "status shows off and level", v, 7);
    chk("R5", "req set", int'(cpu_nmi_req), 1);
    ack_pulse();
    chk("R5", "ack clears req", int'(cpu_nmi_req), 0);
    rd(2'd1, v); chk("R4", "ack leaves flag", v & 1, 1);
    wr(2'd1, 8'h02);
    chk("R7", "re-enable ignored while flag set", int'(phase_oe), 0);
    wr(2'd1, 8'h01);
    tick(filt + 4);
    rd(2'd1, v); chk("R6", "no new event while line held", v & 1, 0);
    chk("R6", "no new req while line held", int'(cpu_nmi_req), 0);
    nmi_in = 1'b0; tick(filt + 4);
    nmi_in = 1'b1; tick(filt + 4);
    rd(2'd1, v); chk("R6", "fresh edge sets flag", v & 1, 1);
    chk("R6", "fresh edge sets req", int'(cpu_nmi_req), 1);
    nmi_in = 1'b0; tick(filt + 4);
    wr(2'd1, 8'h01);
    ack_pulse();
    pwm_in = 6'b010011;
    wr(2'd1, 8'h02);
    chk("R7", "re-enable restores oe", int'(phase_oe), 63);
    chk("R7", "re-enable restores pwm", int'(phase_out), 19);
    rd(2'd1, v); chk("R7", "status after re-enable", v, 0);
  endtask

  task automatic t_enables();
    int v;
    wr(2'd0, 8'h01);
    nmi_in = 1'b1; tick(filt + 4);
    chk("R8", "shut only: oe off", int'(phase_oe), 0);
    chk("R8", "shut only: no req", int'(cpu_nmi_req), 0);
    rd(2'd1, v); chk("R8", "shut only: flag", v & 1, 1);
    cleanup();
    wr(2'd0, 8'h02);
    nmi_in = 1'b1; tick(2 + filt);
    chk("R8", "req only: oe kept at event", int'(phase_oe), 63);
    tick(1);
    chk("R8", "req only: req", int'(cpu_nmi_req), 1);
    chk("R8", "req only: oe kept", int'(phase_oe), 63);
    rd(2'd1, v); chk("R8", "req only: flag", v & 1, 1);
    cleanup();
    wr(2'd0, 8'h03);
  endtask

  task automatic t_same_cycle();
    int v;
    nmi_in = 1'b1; tick(2 + filt);
    reg_addr = 2'd1; reg_wdata = 8'h01; reg_wr = 1'b1;
    tick(1);
    reg_wr = 1'b0;
    rd(2'd1, v); chk("R4", "event beats clear in same cycle", v & 1, 1);
    chk("R5", "req after first event", int'(cpu_nmi_req), 1);
    nmi_in = 1'b0; tick(filt + 4);
    nmi_in = 1'b1; tick(2 + filt);
    cpu_nmi_ack = 1'b1;
    tick(1);
    cpu_nmi_ack = 1'b0;
    chk("R5", "event beats ack in same cycle", int'(cpu_nmi_req), 1);
    ack_pulse();
    chk("R5", "plain ack clears", int'(cpu_nmi_req), 0);
    cleanup();
  endtask

  task automatic t_regmap();
    int v;
    wr(2'd2, 8'd7);
    rd(2'd2, v); chk("R9", "filter readback", v, 7);
    wr(2'd2, 8'd4);
    wr(2'd0, 8'hFC);
    rd(2'd0, v); chk("R9", "ctrl readback upper bits", v, 0);
    wr(2'd0, 8'h03);
    rd(2'd0, v); chk("R9", "ctrl readback", v, 3);
    rd(2'd3, v); chk("R9", "address 3 reads zero", v, 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; nmi_in = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    pwm_in = 6'b101101; cpu_nmi_ack = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_glitch();
    t_main();
    t_enables();
    t_same_cycle();
    t_regmap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule